// File: doc/BRIEF.md
# NCO Nanosecond Time Counter

This block keeps a 44-bit time-of-day count in nanoseconds. A numerically controlled oscillator drives it. On every clock edge a programmable fixed-point step is added to a fractional accumulator that sits below the count, and the carries out of that fraction advance the count. The count wraps to zero after 2^44 - 1 ns, which is roughly 4.9 hours. The step has 3 integer bits and 29 fractional bits. Its nominal value, 0x80000000, means 4.0 ns per tick, which suits a 250 MHz clock. Software trims the frequency by writing a slightly larger or smaller step, shifting the step by ppb * 2^28 / 125e6, rounded.

Software reaches the block through a small word-addressed register port with a single-cycle valid/write strobe. Read data comes back one cycle after the request. The time is split into three segments, each with its own address:

| Address | Bits | Content |
|---|---|---|
| 0 | 3:0 | count bits [3:0] |
| 1 | 31:0 | count bits [35:4] |
| 2 | 7:0 (read), 15:8 (write) | count bits [43:36] |
| 3 | 31:0 | step |

The top segment is read back in data bits [7:0] but written from data bits [15:8]. To load a time, software writes step 0, loads the segments in any order, and then writes a nonzero step to resume counting.

Top module: `nco_time_counter`

## Requirements
- R1: A synchronous active-high reset sets the count and the fraction to 0 and the step to 0x80000000. Counting starts at 4 ns per clock once reset is released.
- R2: On every clock edge with no time-segment write, the 73-bit value {count, fraction} grows by the 32-bit step. At the nominal step the count advances by exactly 4 per clock.
- R3: Fractional carries are kept exactly. With step 0x10000000 (0.5 ns per tick), the count grows by 1 every two clocks.
- R4: While the step is 0, the count holds still. After a nonzero step is written, counting resumes from the held value.
- R5: A write to address 0 replaces count[3:0] with data[3:0], and a write to address 1 replaces count[35:4] with data[31:0]. The other count bits hold and do not advance in that cycle. Any time-segment write clears the fraction.
- R6: A write to address 2 replaces count[43:36] with data[15:8], ignoring every other data bit. A read of address 2 returns count[43:36] in data[7:0] with zeros above.
- R7: A read returns, in the cycle after the request, the addressed segment of the count as it stood in the request cycle. Address 0 returns count[3:0] zero-extended, address 1 returns count[35:4], and address 3 returns the step.
- R8: A step write takes effect from the next clock edge. The edge that captures the write still adds the old step.
- R9: The count wraps modulo 2^44. From all ones at the nominal step, the next value is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Register access strobe for one cycle |
| bus_write | input | 1 | 1 = write, 0 = read (qualified by bus_valid) |
| bus_addr | input | 2 | Word address: 0 low, 1 middle, 2 top, 3 step |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| time_ns | output | 44 | Live nanosecond count |

## Verification
The hardest state to reach from the ports is a half-filled fraction that a time write must discard. The fraction is never visible directly. The bench sets the step to 0.5 ns, runs one tick so the fraction holds a half, and then writes the low segment. It then watches whether the count moves after one more tick or only after two. The wrap is reached the same way. The bench freezes the count with step 0, loads all ones through the three segments with the top byte placed in the shifted lane, restores the nominal step, and checks the count after a single tick.

// File: rtl/nco_time_pkg.sv
package nco_time_pkg;

    localparam int NCO_CNT_W    = 44;
    localparam int NCO_FRAC_W   = 29;
    localparam int NCO_INT_W    = 3;
    localparam int NCO_DATA_W   = 32;
    localparam int NCO_LO_W     = 4;
    localparam int NCO_TOP_W    = 8;
    localparam int NCO_TOP_LANE = 8;
    localparam int NCO_ADDR_W   = 2;

    typedef enum logic [NCO_ADDR_W-1:0] {
        SEL_LO   = 2'd0,
        SEL_MID  = 2'd1,
        SEL_TOP  = 2'd2,
        SEL_STEP = 2'd3
    } nco_sel_e;

endpackage

// File: rtl/nco_bus_decode.sv
module nco_bus_decode
    import nco_time_pkg::*;
#(
    parameter int ADDR_W = NCO_ADDR_W
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              wr_lo,
    output logic              wr_mid,
    output logic              wr_top,
    output logic              wr_step,
    output logic              rd_req
);
    logic     wr_any;
    nco_sel_e sel;

    always_comb begin
        sel     = nco_sel_e'(bus_addr);
        wr_any  = bus_valid && bus_write;
        rd_req  = bus_valid && !bus_write;
        wr_lo   = wr_any && (sel == SEL_LO);
        wr_mid  = wr_any && (sel == SEL_MID);
        wr_top  = wr_any && (sel == SEL_TOP);
        wr_step = wr_any && (sel == SEL_STEP);
    end

    always_comb begin
        assert_one_strobe_R5: assert ($onehot0({wr_lo, wr_mid, wr_top, wr_step, rd_req}));
    end
endmodule

// File: rtl/nco_accum.sv
module nco_accum #(
    parameter int CNT_W    = 44,
    parameter int FRAC_W   = 29,
    parameter int INT_W    = 3,
    parameter int DATA_W   = 32,
    parameter int LO_W     = 4,
    parameter int TOP_W    = 8,
    parameter int TOP_LANE = 8,
    parameter int STEP_W   = INT_W + FRAC_W,
    parameter logic [STEP_W-1:0] STEP_RESET = {1'b1, {(STEP_W-1){1'b0}}}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lo,
    input  logic              wr_mid,
    input  logic              wr_top,
    input  logic              wr_step,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  count,
    output logic [STEP_W-1:0] step
);
    localparam int MID_W = CNT_W - LO_W - TOP_W;
    localparam int SUM_W = CNT_W + FRAC_W;

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [FRAC_W-1:0] frac;
        logic [STEP_W-1:0] step;
    } acc_state_t;

    acc_state_t       state_d, state_q;
    logic [SUM_W-1:0] sum_d;
    logic             time_wr;

    always_comb begin
        state_d = state_q;
        time_wr = wr_lo || wr_mid || wr_top;
        sum_d   = {state_q.count, state_q.frac} + SUM_W'(state_q.step);
        if (time_wr) begin
            state_d.frac = '0;
            if (wr_lo)  state_d.count[LO_W-1:0]       = wdata[LO_W-1:0];
            if (wr_mid) state_d.count[LO_W +: MID_W]   = wdata[MID_W-1:0];
            if (wr_top) state_d.count[CNT_W-1 -: TOP_W] = wdata[TOP_LANE +: TOP_W];
        end else begin
            {state_d.count, state_d.frac} = sum_d;
        end
        if (wr_step) state_d.step = wdata[STEP_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '{count: '0, frac: '0, step: STEP_RESET};
        else     state_q <= state_d;
    end

    assign count = state_q.count;
    assign step  = state_q.step;

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (state_q.count == '0 && state_q.frac == '0 && state_q.step == STEP_RESET));

    assert_hold_at_zero_step_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q.step == '0 && !time_wr) |=> $stable(state_q.count));

    assert_lo_load_R5: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> state_q.count[LO_W-1:0] == $past(wdata[LO_W-1:0]));

    assert_frac_clear_R5: assert property (@(posedge clk) disable iff (rst)
        time_wr |=> state_q.frac == '0);

    assert_top_lane_R6: assert property (@(posedge clk) disable iff (rst)
        wr_top |=> state_q.count[CNT_W-1 -: TOP_W] == $past(wdata[TOP_LANE +: TOP_W]));

    assert_step_take_R8: assert property (@(posedge clk) disable iff (rst)
        wr_step |=> state_q.step == $past(wdata[STEP_W-1:0]));
endmodule

// File: rtl/nco_readback.sv
module nco_readback
    import nco_time_pkg::*;
#(
    parameter int CNT_W  = 44,
    parameter int DATA_W = 32,
    parameter int LO_W   = 4,
    parameter int TOP_W  = 8,
    parameter int STEP_W = 32,
    parameter int ADDR_W = NCO_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  count,
    input  logic [STEP_W-1:0] step,
    output logic [DATA_W-1:0] rdata
);
    localparam int MID_W = CNT_W - LO_W - TOP_W;

    logic [DATA_W-1:0] rdata_d, rdata_q;
    logic [DATA_W-1:0] view;

    always_comb begin
        unique case (nco_sel_e'(addr))
            SEL_LO:   view = DATA_W'(count[LO_W-1:0]);
            SEL_MID:  view = DATA_W'(count[LO_W +: MID_W]);
            SEL_TOP:  view = DATA_W'(count[CNT_W-1 -: TOP_W]);
            default:  view = DATA_W'(step);
        endcase
        rdata_d = rdata_q;
        if (rd_req) rdata_d = view;
    end

    always_ff @(posedge clk) begin
        if (rst) rdata_q <= '0;
        else     rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    assert_read_step_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_req && addr == SEL_STEP) |=> rdata == DATA_W'($past(step)));

    assert_read_top_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_req && addr == SEL_TOP) |=> rdata[DATA_W-1:TOP_W] == '0);
endmodule

// File: rtl/nco_time_counter.sv
module nco_time_counter
    import nco_time_pkg::*;
#(
    parameter int CNT_W    = NCO_CNT_W,
    parameter int FRAC_W   = NCO_FRAC_W,
    parameter int INT_W    = NCO_INT_W,
    parameter int DATA_W   = NCO_DATA_W,
    parameter int LO_W     = NCO_LO_W,
    parameter int TOP_W    = NCO_TOP_W,
    parameter int TOP_LANE = NCO_TOP_LANE,
    parameter int ADDR_W   = NCO_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [CNT_W-1:0]  time_ns
);
    localparam int STEP_W = INT_W + FRAC_W;

    logic              wr_lo, wr_mid, wr_top, wr_step, rd_req;
    logic [STEP_W-1:0] step;

    nco_bus_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .wr_lo     (wr_lo),
        .wr_mid    (wr_mid),
        .wr_top    (wr_top),
        .wr_step   (wr_step),
        .rd_req    (rd_req)
    );

    nco_accum #(
        .CNT_W    (CNT_W),
        .FRAC_W   (FRAC_W),
        .INT_W    (INT_W),
        .DATA_W   (DATA_W),
        .LO_W     (LO_W),
        .TOP_W    (TOP_W),
        .TOP_LANE (TOP_LANE)
    ) u_accum (
        .clk     (clk),
        .rst     (rst),
        .wr_lo   (wr_lo),
        .wr_mid  (wr_mid),
        .wr_top  (wr_top),
        .wr_step (wr_step),
        .wdata   (bus_wdata),
        .count   (time_ns),
        .step    (step)
    );

    nco_readback #(
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W),
        .LO_W   (LO_W),
        .TOP_W  (TOP_W),
        .STEP_W (STEP_W),
        .ADDR_W (ADDR_W)
    ) u_readback (
        .clk    (clk),
        .rst    (rst),
        .rd_req (rd_req),
        .addr   (bus_addr),
        .count  (time_ns),
        .step   (step),
        .rdata  (bus_rdata)
    );
endmodule

// File: tb/nco_time_counter_test.sv
module nco_time_counter_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [43:0] time_ns;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    nco_time_counter uut (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .time_ns   (time_ns)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [31:0] d, output logic [43:0] snap);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        snap = time_ns;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic test_reset();
        logic [31:0] d; logic [43:0] s;
        tick(3);
        check("R1 count in reset", time_ns, 0);
        rst = 1'b0;
        tick(1);
        check("R1 first tick after reset", time_ns, 4);
        bus_rd(2'd3, d, s);
        check("R1 step reset value", d, 32'h8000_0000);
    endtask

    task automatic test_nominal();
        logic [43:0] t0;
        t0 = time_ns;
        tick(10);
        check("R2 nominal 4 ns per tick", time_ns, t0 + 44'd40);
    endtask

    task automatic test_freeze();
        logic [43:0] t0;
        t0 = time_ns;
        bus_wr(2'd3, 32'h0);
        check("R8 old step used on write edge", time_ns, t0 + 44'd4);
        tick(20);
        check("R4 frozen at zero step", time_ns, t0 + 44'd4);
    endtask

    task automatic test_load();
        logic [31:0] d; logic [43:0] s;
        bus_wr(2'd0, 32'hFFFF_FFF5);
        bus_wr(2'd1, 32'h1234_5678);
        bus_wr(2'd2, 32'hFFFF_AB77);
        check("R5 R6 segment load", time_ns, 44'hAB_1234_5678_5);
        bus_rd(2'd2, d, s);
        check("R6 top read in low byte", d, 32'h0000_00AB);
        bus_rd(2'd1, d, s);
        check("R7 middle read", d, 32'h1234_5678);
        bus_rd(2'd0, d, s);
        check("R7 low read", d, 32'h5);
        bus_rd(2'd3, d, s);
        check("R4 step reads zero", d, 32'h0);
    endtask

    task automatic test_fraction();
        logic [43:0] t0;
        t0 = time_ns;
        bus_wr(2'd3, 32'h1000_0000);
        check("R8 zero step still applied", time_ns, t0);
        tick(1);
        check("R3 half tick no carry", time_ns, t0);
        tick(1);
        check("R3 carry after two ticks", time_ns, t0 + 44'd1);
        tick(6);
        check("R3 eight half ticks", time_ns, t0 + 44'd4);
    endtask

    task automatic test_frac_clear();
        logic [43:0] t1;
        tick(1);
        t1 = time_ns;
        bus_wr(2'd0, 32'h3);
        check("R5 low load holds others", time_ns, {t1[43:4], 4'h3});
        tick(1);
        check("R5 fraction cleared by load", time_ns, {t1[43:4], 4'h3});
        tick(1);
        check("R3 carry after clear", time_ns, {t1[43:4], 4'h3} + 44'd1);
    endtask

    task automatic test_wrap();
        logic [31:0] d; logic [43:0] s;
        bus_wr(2'd3, 32'h0);
        bus_wr(2'd0, 32'hF);
        bus_wr(2'd1, 32'hFFFF_FFFF);
        bus_wr(2'd2, 32'h0000_FF00);
        check("R6 all ones loaded", time_ns, 44'hFFF_FFFF_FFFF);
        bus_wr(2'd3, 32'h8000_0000);
        check("R8 held on resume edge", time_ns, 44'hFFF_FFFF_FFFF);
        tick(1);
        check("R9 wrap to 3", time_ns, 44'd3);
        tick(1);
        check("R4 resumes counting", time_ns, 44'd7);
        bus_rd(2'd0, d, s);
        check("R7 live low snapshot", d, {28'h0, s[3:0]});
        bus_rd(2'd1, d, s);
        check("R7 live middle snapshot", d, s[35:4]);
    endtask

    initial begin
        @(negedge clk);
        test_reset();
        test_nominal();
        test_freeze();
        test_load();
        test_fraction();
        test_frac_clear();
        test_wrap();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule